// File: doc/BRIEF.md
# Three-Domain Reset Generator with Cause Flags

This block turns a set of reset events into three active-low reset outputs of different reach. The system reset clears core logic. The power reset clears everything except the battery-backed domain. The backup reset clears only the battery-backed registers. Each domain has its own set of triggers. Any power reset also drives the system reset. Every output stays low for a fixed number of clock cycles after its last trigger and is released on a clock edge.

The block also keeps a small bank of sticky cause flags, one for each source class. Software reads them to find out why the chip last restarted. A system reset leaves the flags intact. They are cleared only by a power reset or by an explicit software write, and the newest cause is recorded after any clearing. A second register holds a software-driven backup-reset bit, which keeps the backup domain in reset for as long as the bit is set.

The controller's own registers are initialised by the power-detect input. The backup stretcher is initialised by the backup power-up event.

Top module: `rstctl_domains`

## Requirements
- R1: The system reset (`sys_rst_n` low) is triggered by each of these: the external pin held low (seen after a SYNC_STAGES-flop synchronizer), window watchdog expiry, independent watchdog expiry, a software request, or a low-power-management request. None of these touches `pwr_rst_n` or `bkp_rst_n`.
- R2: A power reset (`pwr_rst_n` low) is triggered by the power-detect level or by a standby-exit strobe. A power reset also drives `sys_rst_n` low for the same span and leaves `bkp_rst_n` alone.
- R3: The backup reset (`bkp_rst_n` low) is triggered by the backup power-up strobe or by the software backup-reset bit. Neither of these touches `sys_rst_n` or `pwr_rst_n`.
- R4: A trigger that is sampled high on N consecutive clock edges holds its output low for exactly N + HOLD_CYCLES consecutive cycles. The output goes low after the first such edge and is released by a register.
- R5: Writing register address 1 sets the backup-reset bit from wdata bit 0, and the bit reads back at bit 0 of address 1. While the bit is 1, `bkp_rst_n` stays low. After the bit is written back to 0, `bkp_rst_n` is low for HOLD_CYCLES + 1 more cycles, counted from the write edge.
- R6: Address 0 reads the cause flags: bit 0 pin, bit 1 window watchdog, bit 2 independent watchdog, bit 3 software, bit 4 low-power, bit 5 power (power detect or standby exit). The other bits read 0. Flags are sticky and accumulate, and a system reset does not clear them.
- R7: A write to address 0 with wdata bit 7 = 1 clears all flags. A flag whose source is active in the same cycle ends up set. A write to address 0 with bit 7 = 0 changes nothing.
- R8: A power reset clears all flags and the backup-reset bit, then sets flag bit 5. After power-up the flags read 0x20 and address 1 reads 0.
- R9: A system reset alone does not clear the backup-reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wwdg_expire | input | 1 | Window watchdog expiry, active high |
| iwdg_expire | input | 1 | Independent watchdog expiry, active high |
| sw_reset_req | input | 1 | Software system-reset request, active high |
| lpm_reset_req | input | 1 | Low-power-management reset request, active high |
| pwr_detect | input | 1 | Power-on/power-down detect level, active high; also initialises the controller |
| standby_exit | input | 1 | Exit-from-standby strobe |
| vbat_powerup | input | 1 | Backup domain power-up strobe (after loss of both supplies) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 flags, 1 backup control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| sys_rst_n | output | 1 | System reset, active low |
| pwr_rst_n | output | 1 | Power-domain reset, active low |
| bkp_rst_n | output | 1 | Backup-domain reset, active low |

## Verification
Two events can fall in the same clock edge: a remove-flags write and a new reset source. The bench provokes this by raising the flag-clear write and the low-power request on the same edge, on top of an older software flag. It judges the result by reading the flags afterwards, which must hold only the low-power bit. A second collision is a standby exit while the backup-reset bit is set. There the bench counts how long the backup reset stays low as the power reset clears the bit, and checks that the bit reads back 0.

// File: rtl/rstctl_domains.sv
module rstctl_domains #(
  parameter int HOLD_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic       wwdg_expire,
  input  logic       iwdg_expire,
  input  logic       sw_reset_req,
  input  logic       lpm_reset_req,
  input  logic       pwr_detect,
  input  logic       standby_exit,
  input  logic       vbat_powerup,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sys_rst_n,
  output logic       pwr_rst_n,
  output logic       bkp_rst_n
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYCLES);
  localparam int NFLAG = 6;
  localparam int CLR_BIT = 7;

  logic [SYNC_STAGES-1:0] pin_sync;
  logic pin_low, pwr_trig, sys_trig, bkp_trig, clr_wr;
  logic [NFLAG-1:0] flag_set, flags_q;
  logic bkp_ctl_q;
  logic [2:0] dom_trig, dom_act;
  logic unused_wdata;

  always_ff @(posedge clk)
    if (pwr_detect) pin_sync <= '1;
    else            pin_sync <= {pin_sync[SYNC_STAGES-2:0], ext_rst_n};

  assign pin_low  = ~pin_sync[SYNC_STAGES-1];
  assign pwr_trig = pwr_detect | standby_exit;
  assign sys_trig = pin_low | wwdg_expire | iwdg_expire | sw_reset_req
                  | lpm_reset_req | pwr_trig;
  assign bkp_trig = vbat_powerup | bkp_ctl_q;
  assign dom_trig = {bkp_trig, pwr_trig, sys_trig};

  for (genvar gi = 0; gi < 3; gi++) begin : g_stretch
    logic [CW-1:0] cnt_q;
    logic          act_q;
    always_ff @(posedge clk) begin
      if (dom_trig[gi]) begin
        cnt_q <= HOLD_LD;
        act_q <= 1'b1;
      end else begin
        act_q <= (cnt_q != '0);
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
    end
    assign dom_act[gi] = act_q;
  end

  assign sys_rst_n = ~dom_act[0];
  assign pwr_rst_n = ~dom_act[1];
  assign bkp_rst_n = ~dom_act[2];

  assign flag_set = {pwr_trig, lpm_reset_req, sw_reset_req,
                     iwdg_expire, wwdg_expire, pin_low};
  assign clr_wr   = reg_wr & ~reg_addr & reg_wdata[CLR_BIT];

  always_ff @(posedge clk)
    flags_q <= ((pwr_trig | clr_wr) ? '0 : flags_q) | flag_set;

  always_ff @(posedge clk)
    if (pwr_trig)               bkp_ctl_q <= 1'b0;
    else if (reg_wr && reg_addr) bkp_ctl_q <= reg_wdata[0];

  assign reg_rdata = reg_addr ? {7'b0, bkp_ctl_q}
                              : {{(8-NFLAG){1'b0}}, flags_q};

  assign unused_wdata = ^reg_wdata[6:1];

endmodule

// File: rtl/rstctl_domains_chk.sv
module rstctl_domains_chk #(
  parameter int HOLD_CYCLES = 4
) (
  input logic       clk,
  input logic       pwr_detect,
  input logic       standby_exit,
  input logic       vbat_powerup,
  input logic       sys_trig,
  input logic       bkp_trig,
  input logic       bkp_ctl,
  input logic       clr_wr,
  input logic [5:0] flag_set,
  input logic [5:0] flags,
  input logic       sys_rst_n,
  input logic       pwr_rst_n,
  input logic       bkp_rst_n
);
  localparam int QW = $clog2(HOLD_CYCLES + 3);
  localparam logic [QW-1:0] QSAT = QW'(HOLD_CYCLES + 2);
  localparam logic [QW-1:0] QREL = QW'(HOLD_CYCLES + 1);

  logic [QW-1:0] sys_quiet, bkp_quiet;

  always_ff @(posedge clk)
    if (sys_trig) sys_quiet <= '0;
    else if (sys_quiet != QSAT) sys_quiet <= sys_quiet + 1'b1;

  always_ff @(posedge clk)
    if (bkp_trig) bkp_quiet <= '0;
    else if (bkp_quiet != QSAT) bkp_quiet <= bkp_quiet + 1'b1;

  a_r1_sys_on_trigger: assert property (@(posedge clk)
    disable iff (pwr_detect || vbat_powerup) sys_trig |=> !sys_rst_n);

  a_r2_pwr_within_sys: assert property (@(posedge clk)
    disable iff (pwr_detect || vbat_powerup) !pwr_rst_n |-> !sys_rst_n);

  a_r3_bkp_on_trigger: assert property (@(posedge clk)
    disable iff (pwr_detect || vbat_powerup) bkp_trig |=> !bkp_rst_n);

  a_r4_sys_release_gap: assert property (@(posedge clk)
    disable iff (pwr_detect || vbat_powerup) $rose(sys_rst_n) |-> sys_quiet == QREL);

  a_r4_bkp_release_gap: assert property (@(posedge clk)
    disable iff (pwr_detect || vbat_powerup) $rose(bkp_rst_n) |-> bkp_quiet == QREL);

  a_r5_ctl_holds_bkp: assert property (@(posedge clk)
    disable iff (pwr_detect || vbat_powerup) bkp_ctl |=> !bkp_rst_n);

  a_r6_flags_sticky: assert property (@(posedge clk)
    disable iff (pwr_detect || vbat_powerup)
    (!standby_exit && !clr_wr) |=> ((flags & $past(flags)) == $past(flags)));

  a_r7_newest_kept: assert property (@(posedge clk)
    disable iff (pwr_detect || vbat_powerup) clr_wr |=> flags == $past(flag_set));

  a_r8_standby_clears: assert property (@(posedge clk)
    disable iff (pwr_detect || vbat_powerup) standby_exit |=> flags == $past(flag_set));
endmodule

bind rstctl_domains rstctl_domains_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (
  .clk(clk), .pwr_detect(pwr_detect), .standby_exit(standby_exit),
  .vbat_powerup(vbat_powerup), .sys_trig(sys_trig), .bkp_trig(bkp_trig),
  .bkp_ctl(bkp_ctl_q), .clr_wr(clr_wr), .flag_set(flag_set), .flags(flags_q),
  .sys_rst_n(sys_rst_n), .pwr_rst_n(pwr_rst_n), .bkp_rst_n(bkp_rst_n));

// File: tb/rstctl_domains_tb_top.sv
module rstctl_domains_tb_top;
  localparam int HOLD = 4;
  localparam int WIN  = HOLD + 20;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b1, wwdg_expire = 1'b0, iwdg_expire = 1'b0;
  logic sw_reset_req = 1'b0, lpm_reset_req = 1'b0;
  logic pwr_detect = 1'b1, standby_exit = 1'b0, vbat_powerup = 1'b1;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic sys_rst_n, pwr_rst_n, bkp_rst_n;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  rstctl_domains #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .ext_rst_n(ext_rst_n), .wwdg_expire(wwdg_expire),
    .iwdg_expire(iwdg_expire), .sw_reset_req(sw_reset_req),
    .lpm_reset_req(lpm_reset_req), .pwr_detect(pwr_detect),
    .standby_exit(standby_exit), .vbat_powerup(vbat_powerup),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n), .pwr_rst_n(pwr_rst_n),
    .bkp_rst_n(bkp_rst_n));

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: ext_rst_n = ~v;
      1: wwdg_expire = v;
      2: iwdg_expire = v;
      3: sw_reset_req = v;
      4: lpm_reset_req = v;
      5: pwr_detect = v;
      6: standby_exit = v;
      default: vbat_powerup = v;
    endcase
  endtask

  task automatic run_src(input int s, input int n, output int ls, output int lp, output int lb);
    ls = 0; lp = 0; lb = 0;
    @(negedge clk); set_src(s, 1'b1);
    repeat (n) begin
      @(negedge clk);
      ls += int'(!sys_rst_n); lp += int'(!pwr_rst_n); lb += int'(!bkp_rst_n);
    end
    set_src(s, 1'b0);
    repeat (WIN) begin
      @(negedge clk);
      ls += int'(!sys_rst_n); lp += int'(!pwr_rst_n); lb += int'(!bkp_rst_n);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output int d);
    reg_addr = a; #1; d = int'(reg_rdata);
  endtask

  task automatic t_reset_state();
    int d;
    chk("R8 sys released", int'(sys_rst_n), 1);
    chk("R8 pwr released", int'(pwr_rst_n), 1);
    chk("R8 bkp released", int'(bkp_rst_n), 1);
    rd(1'b0, d); chk("R8 flags after power-up", d, 32'h20);
    rd(1'b1, d); chk("R8 bkp bit after power-up", d, 0);
  endtask

  task automatic t_sys_sources();
    int ls, lp, lb, d;
    for (int s = 0; s < 5; s++) begin
      wr(1'b0, 8'h80);
      run_src(s, 1, ls, lp, lb);
      chk("R1/R4 sys low span", ls, 1 + HOLD);
      chk("R1 pwr untouched", lp, 0);
      chk("R1 bkp untouched", lb, 0);
      rd(1'b0, d); chk("R6 single cause flag", d, 1 << s);
    end
  endtask

  task automatic t_stretch();
    int ls, lp, lb;
    run_src(1, 3, ls, lp, lb); chk("R4 3-cycle trigger", ls, 3 + HOLD);
    run_src(0, 6, ls, lp, lb); chk("R4 6-cycle pin low", ls, 6 + HOLD);
    chk("R1 pin leaves pwr", lp, 0);
  endtask

  task automatic t_power();
    int ls, lp, lb, d;
    run_src(3, 1, ls, lp, lb);
    wr(1'b1, 8'h01);
    run_src(6, 1, ls, lp, lb);
    chk("R2 standby sys span", ls, 1 + HOLD);
    chk("R2 standby pwr span", lp, 1 + HOLD);
    chk("R8 bkp bit cleared ends bkp", lb, 1 + HOLD);
    rd(1'b0, d); chk("R8 flags after standby", d, 32'h20);
    rd(1'b1, d); chk("R8 bkp bit cleared", d, 0);
    run_src(5, 5, ls, lp, lb);
    chk("R2 detect sys span", ls, 5 + HOLD);
    chk("R2 detect pwr span", lp, 5 + HOLD);
    chk("R2 detect leaves bkp", lb, 0);
  endtask

  task automatic t_backup();
    int ls, lp, lb, d, n;
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h01);
    ls = 0; lp = 0; lb = 0;
    repeat (10) begin
      @(negedge clk);
      ls += int'(!sys_rst_n); lp += int'(!pwr_rst_n); lb += int'(!bkp_rst_n);
    end
    chk("R5 bkp held by bit", lb, 10);
    chk("R3 bit leaves sys", ls, 0);
    chk("R3 bit leaves pwr", lp, 0);
    rd(1'b1, d); chk("R5 bit readback", d, 1);
    run_src(2, 1, ls, lp, lb);
    rd(1'b1, d); chk("R9 bit survives sys reset", d, 1);
    wr(1'b1, 8'h00);
    n = 0;
    repeat (WIN) begin
      n += int'(!bkp_rst_n);
      @(negedge clk);
    end
    chk("R5 release after bit clear", n, 1 + HOLD);
    run_src(7, 1, ls, lp, lb);
    chk("R3 powerup bkp span", lb, 1 + HOLD);
    chk("R3 powerup leaves sys", ls, 0);
    chk("R3 powerup leaves pwr", lp, 0);
    rd(1'b0, d); chk("R3 powerup leaves flags", d, 32'h04);
  endtask

  task automatic t_flags();
    int ls, lp, lb, d;
    wr(1'b0, 8'h80);
    run_src(3, 1, ls, lp, lb);
    run_src(4, 1, ls, lp, lb);
    rd(1'b0, d); chk("R6 flags accumulate", d, 32'h18);
    wr(1'b0, 8'h3F);
    rd(1'b0, d); chk("R7 write without bit7 ignored", d, 32'h18);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h80; lpm_reset_req = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00; lpm_reset_req = 1'b0;
    rd(1'b0, d); chk("R7 clear with same-cycle source", d, 32'h10);
    wr(1'b0, 8'h80);
    rd(1'b0, d); chk("R7 plain clear", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    pwr_detect = 1'b0; vbat_powerup = 1'b0;
    repeat (HOLD + 4) @(negedge clk);
    t_reset_state();
    t_sys_sources();
    t_stretch();
    t_power();
    t_backup();
    t_flags();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule